// File: doc/BRIEF.md
# Banked GPIO Port Register Block

This block holds the configuration of one bank of 32 general-purpose pins and drives their pads. Every pin has a 4-bit function code, a stored output bit, a 2-bit drive-strength code and a 2-bit pull code. The function code decides what reaches the pad:

- a plain input;
- a GPIO output driven from the stored bit;
- a pass-through of an alternate-function output and its enable;
- a disabled pin.

Pad inputs pass through a two-flop synchroniser. Reading the data word returns either the synchronised pad level or the stored output bit, depending on each pin's mode.

Software reaches the block through a word-addressed request/acknowledge port. The bus sequencer has two states:

- **ST_IDLE** accepts a request. Transition *accept*: when `req_valid` is high, a write is committed or the read word is captured, and the sequencer moves to ST_ACK.
- **ST_ACK** raises `req_ack` for exactly one cycle. Transition *release*: the sequencer returns unconditionally to ST_IDLE, and a request that is present during ST_ACK is not taken.

The requester holds `req_valid` until it sees `req_ack`. It then drops `req_valid` before the next clock edge.

Word map, given as the word index and the byte offset, which is 4 times the index:

| Word | Byte offset | Contents |
|------|-------------|----------|
| 0-3 | 0x00-0x0C | Function codes |
| 4 | 0x10 | Pin data |
| 5-6 | 0x14-0x18 | Drive codes |
| 7-8 | 0x1C-0x20 | Pull codes |

The register image of one bank spans 0x24 bytes.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every function code is 7, and the data, drive and pull words are 0. Read back, words 0-3 give 0x77777777 and words 4-8 give 0. `pad_oe`, `pad_out`, `pad_drive` and `pad_pull` are all zero.
- R2: A request seen in ST_IDLE is accepted on that clock edge. `req_ack` is high for exactly the following cycle, and `req_rdata` is valid then. A request still present in ST_ACK is ignored and has no effect on the registers.
- R3: The function code of pin p lives in word p/8, bits [4*(p%8)+3 : 4*(p%8)]. Every word written to 0-3 reads back unchanged.
- R4: Function code 0 puts the pin in input mode: `pad_oe` and `pad_out` are 0.
- R5: Function code 1 makes the pin a GPIO output: `pad_oe` is 1, and `pad_out` equals the pin's bit in word 4.
- R6: Function codes 2-6 and 8-15 select the alternate function: `pad_out` follows `alt_out`, and `pad_oe` follows `alt_oe`, for that pin.
- R7: Function code 7 disables the pin: `pad_oe` and `pad_out` are 0, whatever `alt_oe` and `alt_out` carry.
- R8: A write to word 4 stores all 32 output bits. A read of word 4 returns the stored bit for pins with code 1. For all other pins it returns the pad level after two synchronising flops. A pad change made together with a read request is not visible in that read, but is visible in a read accepted two edges later.
- R9: The drive code of pin p lives in word 5 + p/16, bits [2*(p%16)+1 : 2*(p%16)]. It appears unchanged on `pad_drive[2p+1:2p]`.
- R10: The pull code of pin p lives in word 7 + p/16, bits [2*(p%16)+1 : 2*(p%16)]. On `pad_pull[2p+1:2p]`, 00 means no pull, 01 pull-up and 10 pull-down. The reserved code 11 is driven as 00, yet still reads back as 11.
- R11: Word indices 9-15 are unmapped. They read as 0, and writes to them change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 4 | Word index (byte offset bits 5:2) |
| req_wdata | input | 32 | Write data |
| req_ack | output | 1 | One-cycle acknowledge |
| req_rdata | output | 32 | Read data, valid with req_ack |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| alt_out | input | 32 | Alternate-function output values |
| alt_oe | input | 32 | Alternate-function output enables |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_drive | output | 64 | Drive-strength code per pin |
| pad_pull | output | 64 | Pull mode per pin (00 none, 01 up, 10 down) |

## Verification
The hardest situation to reach from the ports is a read of the data word whose pins mix modes while the pad level is still crossing the synchroniser. The answer then depends on each pin's function code, on the stored bit and on how many edges have passed since the pad changed. A directed sequence changes `pad_in` in the same cycle as a read request, and expects the old level first and the new level on the following read. A second directed sequence keeps a request asserted, with altered contents, into ST_ACK and confirms that it leaves no trace. Random traffic then mixes random function codes, pad levels and alternate-function inputs, so that every mode meets the data read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PINS          = 32;
    localparam int WORD_W        = 32;
    localparam int FSEL_W        = 4;
    localparam int DRV_W         = 2;
    localparam int PULL_W        = 2;
    localparam int WIDX_W        = 4;
    localparam int FSEL_PER_WORD = WORD_W / FSEL_W;
    localparam int DRV_PER_WORD  = WORD_W / DRV_W;
    localparam int PULL_PER_WORD = WORD_W / PULL_W;
    localparam int FSEL_WORDS    = PINS / FSEL_PER_WORD;
    localparam int DRV_WORDS     = PINS / DRV_PER_WORD;
    localparam int PULL_WORDS    = PINS / PULL_PER_WORD;
    localparam int DATA_WORD     = FSEL_WORDS;
    localparam int DRV_WORD0     = DATA_WORD + 1;
    localparam int PULL_WORD0    = DRV_WORD0 + DRV_WORDS;
    localparam int MAP_WORDS     = PULL_WORD0 + PULL_WORDS;

    typedef logic [FSEL_W-1:0] fsel_t;
    localparam fsel_t FSEL_IN  = 4'd0;
    localparam fsel_t FSEL_OUT = 4'd1;
    localparam fsel_t FSEL_OFF = 4'd7;

    localparam logic [PULL_W-1:0] PULL_NONE = 2'b00;
    localparam logic [PULL_W-1:0] PULL_RSVD = 2'b11;

    localparam logic [WORD_W-1:0] FSEL_RST_WORD = {FSEL_PER_WORD{FSEL_OFF}};

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [WIDX_W-1:0]        widx,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [PINS-1:0]          data_view,
    output logic [PINS*FSEL_W-1:0]   fsel_flat,
    output logic [PINS-1:0]          dout,
    output logic [PINS*DRV_W-1:0]    drv_flat,
    output logic [PINS*PULL_W-1:0]   pull_flat,
    output logic [WORD_W-1:0]        rd_word
);
    logic [WORD_W-1:0] fsel_q [FSEL_WORDS];
    logic [WORD_W-1:0] drv_q  [DRV_WORDS];
    logic [WORD_W-1:0] pull_q [PULL_WORDS];
    logic [PINS-1:0]   dout_q;

    for (genvar w = 0; w < FSEL_WORDS; w++) begin : g_fsel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      fsel_q[w] <= FSEL_RST_WORD;
            else if (wr_stb && widx == WIDX_W'(w))           fsel_q[w] <= wdata;
        end
        assign fsel_flat[w*WORD_W +: WORD_W] = fsel_q[w];
    end

    for (genvar w = 0; w < DRV_WORDS; w++) begin : g_drv
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      drv_q[w] <= '0;
            else if (wr_stb && widx == WIDX_W'(DRV_WORD0 + w)) drv_q[w] <= wdata;
        end
        assign drv_flat[w*WORD_W +: WORD_W] = drv_q[w];
    end

    for (genvar w = 0; w < PULL_WORDS; w++) begin : g_pull
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        pull_q[w] <= '0;
            else if (wr_stb && widx == WIDX_W'(PULL_WORD0 + w)) pull_q[w] <= wdata;
        end
        assign pull_flat[w*WORD_W +: WORD_W] = pull_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     dout_q <= '0;
        else if (wr_stb && widx == WIDX_W'(DATA_WORD))  dout_q <= wdata;
    end
    assign dout = dout_q;

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < FSEL_WORDS; w++)
            if (widx == WIDX_W'(w)) rd_word = fsel_q[w];
        if (widx == WIDX_W'(DATA_WORD)) rd_word = data_view;
        for (int w = 0; w < DRV_WORDS; w++)
            if (widx == WIDX_W'(DRV_WORD0 + w)) rd_word = drv_q[w];
        for (int w = 0; w < PULL_WORDS; w++)
            if (widx == WIDX_W'(PULL_WORD0 + w)) rd_word = pull_q[w];
    end
endmodule

// File: rtl/gpio_bank_pinmux.sv
module gpio_bank_pinmux
    import gpio_bank_pkg::*;
(
    input  logic [PINS*FSEL_W-1:0]  fsel_flat,
    input  logic [PINS-1:0]         dout,
    input  logic [PINS*PULL_W-1:0]  pull_flat,
    input  logic [PINS-1:0]         alt_out,
    input  logic [PINS-1:0]         alt_oe,
    output logic [PINS-1:0]         pad_out,
    output logic [PINS-1:0]         pad_oe,
    output logic [PINS*PULL_W-1:0]  pad_pull,
    output logic [PINS-1:0]         gpio_mode
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        fsel_t             code;
        logic [PULL_W-1:0] pcode;
        logic              o_v, e_v, g_v;

        assign code  = fsel_flat[p*FSEL_W +: FSEL_W];
        assign pcode = pull_flat[p*PULL_W +: PULL_W];

        always_comb begin
            o_v = 1'b0;
            e_v = 1'b0;
            g_v = 1'b0;
            if (code == FSEL_OUT) begin
                o_v = dout[p];
                e_v = 1'b1;
                g_v = 1'b1;
            end else if (code != FSEL_IN && code != FSEL_OFF) begin
                o_v = alt_out[p];
                e_v = alt_oe[p];
            end
        end

        assign pad_out[p]                   = o_v;
        assign pad_oe[p]                    = e_v;
        assign gpio_mode[p]                 = g_v;
        assign pad_pull[p*PULL_W +: PULL_W] = (pcode == PULL_RSVD) ? PULL_NONE : pcode;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [WIDX_W-1:0]       req_word,
    input  logic [WORD_W-1:0]       req_wdata,
    output logic                    req_ack,
    output logic [WORD_W-1:0]       req_rdata,
    input  logic [PINS-1:0]         pad_in,
    input  logic [PINS-1:0]         alt_out,
    input  logic [PINS-1:0]         alt_oe,
    output logic [PINS-1:0]         pad_out,
    output logic [PINS-1:0]         pad_oe,
    output logic [PINS*DRV_W-1:0]   pad_drive,
    output logic [PINS*PULL_W-1:0]  pad_pull
);
    bus_state_e              state_q, state_d;
    logic                    accept;
    logic [WORD_W-1:0]       rd_word, rdata_q;
    logic [PINS*FSEL_W-1:0]  fsel_flat;
    logic [PINS-1:0]         dout_bits, pad_sync, gpio_mode, data_view;
    logic [PINS*PULL_W-1:0]  pull_flat;

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
        endcase
    end

    // Sequencer: outputs
    always_comb begin
        accept  = 1'b0;
        req_ack = 1'b0;
        unique case (state_q)
            ST_IDLE: accept  = req_valid;
            ST_ACK:  req_ack = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= req_write ? '0 : rd_word;
    end
    assign req_rdata = rdata_q;

    gpio_bank_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    assign data_view = (gpio_mode & dout_bits) | (~gpio_mode & pad_sync);

    gpio_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (accept & req_write),
        .widx      (req_word),
        .wdata     (req_wdata),
        .data_view (data_view),
        .fsel_flat (fsel_flat),
        .dout      (dout_bits),
        .drv_flat  (pad_drive),
        .pull_flat (pull_flat),
        .rd_word   (rd_word)
    );

    gpio_bank_pinmux u_mux (
        .fsel_flat (fsel_flat),
        .dout      (dout_bits),
        .pull_flat (pull_flat),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pull  (pad_pull),
        .gpio_mode (gpio_mode)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ack,
    input logic [PINS-1:0]         pad_out,
    input logic [PINS-1:0]         pad_oe,
    input logic [PINS*PULL_W-1:0]  pad_pull,
    input logic [PINS-1:0]         alt_out,
    input logic [PINS-1:0]         alt_oe,
    input logic [PINS*FSEL_W-1:0]  fsel_flat,
    input logic [PINS-1:0]         dout_bits
);
    logic [PINS-1:0] quiet_m, gpio_m, alt_m, rsvd_m;

    always_comb begin
        for (int p = 0; p < PINS; p++) begin
            quiet_m[p] = (fsel_flat[p*FSEL_W +: FSEL_W] == 4'd0) ||
                         (fsel_flat[p*FSEL_W +: FSEL_W] == 4'd7);
            gpio_m[p]  = (fsel_flat[p*FSEL_W +: FSEL_W] == 4'd1);
            alt_m[p]   = !quiet_m[p] && !gpio_m[p];
            rsvd_m[p]  = pad_pull[p*PULL_W] && pad_pull[p*PULL_W+1];
        end
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R2
    req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> req_ack);

    // R4
    quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out) & quiet_m) == '0);

    // R5
    gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ dout_bits) & gpio_m) == '0) && ((pad_oe & gpio_m) == gpio_m));

    // R6
    alt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ alt_out) & alt_m) == '0) && (((pad_oe ^ alt_oe) & alt_m) == '0));

    // R10
    no_rsvd_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_m == '0);
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe),
    .fsel_flat (fsel_flat),
    .dout_bits (dout_bits)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_ack;
    logic [3:0]  req_word;
    logic [31:0] req_wdata, req_rdata;
    logic [31:0] pad_in, alt_out, alt_oe, pad_out, pad_oe;
    logic [63:0] pad_drive, pad_pull;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_fsel [4];
    logic [31:0] m_dout;
    logic [31:0] m_drv  [2];
    logic [31:0] m_pull [2];

    always #2.5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_drive(pad_drive), .pad_pull(pad_pull)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] code_of(input int p);
        return m_fsel[p/8][4*(p%8) +: 4];
    endfunction

    function automatic logic [31:0] exp_read(input int w, input logic [31:0] pad);
        logic [31:0] v;
        v = '0;
        if (w < 4) v = m_fsel[w];
        else if (w == 4) begin
            for (int p = 0; p < 32; p++) v[p] = (code_of(p) == 4'd1) ? m_dout[p] : pad[p];
        end
        else if (w < 7) v = m_drv[w-5];
        else if (w < 9) v = m_pull[w-7];
        return v;
    endfunction

    task automatic model_write(input int w, input logic [31:0] d);
        if (w < 4)      m_fsel[w]   = d;
        else if (w == 4) m_dout     = d;
        else if (w < 7) m_drv[w-5]  = d;
        else if (w < 9) m_pull[w-7] = d;
    endtask

    // Caller is at a falling edge; returns at a falling edge.
    task automatic bus(input bit we, input int w, input logic [31:0] d, output logic [31:0] rd);
        req_valid = 1'b1; req_write = we; req_word = w[3:0]; req_wdata = d;
        @(negedge clk);
        chk(req_ack === 1'b1, "R2 ack after accept", {63'd0, req_ack}, 64'd1);
        rd = req_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ack === 1'b0, "R2 ack one cycle", {63'd0, req_ack}, 64'd0);
        if (we) model_write(w, d);
    endtask

    task automatic rd_chk(input int w, input string tag);
        logic [31:0] r;
        bus(1'b0, w, 32'd0, r);
        chk(r === exp_read(w, pad_in), tag, {32'd0, r}, {32'd0, exp_read(w, pad_in)});
    endtask

    task automatic pads_chk(input string tag);
        logic [31:0] eo, ee;
        logic [63:0] ep;
        for (int p = 0; p < 32; p++) begin
            logic [3:0] c;
            logic [1:0] pc;
            c = code_of(p);
            pc = m_pull[p/16][2*(p%16) +: 2];
            ep[2*p +: 2] = (pc == 2'b11) ? 2'b00 : pc;
            if (c == 4'd0 || c == 4'd7) begin eo[p] = 1'b0; ee[p] = 1'b0; end
            else if (c == 4'd1)         begin eo[p] = m_dout[p]; ee[p] = 1'b1; end
            else                        begin eo[p] = alt_out[p]; ee[p] = alt_oe[p]; end
        end
        chk(pad_out === eo, {tag, " R4 R5 R6 R7 pad_out"}, {32'd0, pad_out}, {32'd0, eo});
        chk(pad_oe  === ee, {tag, " R4 R5 R6 R7 pad_oe"},  {32'd0, pad_oe},  {32'd0, ee});
        chk(pad_pull === ep, {tag, " R10 pad_pull"}, pad_pull, ep);
        chk(pad_drive === {m_drv[1], m_drv[0]}, {tag, " R9 pad_drive"}, pad_drive, {m_drv[1], m_drv[0]});
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1729));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = '0; req_wdata = '0;
        pad_in = '0; alt_out = '0; alt_oe = '0;
        for (int w = 0; w < 4; w++) m_fsel[w] = 32'h7777_7777;
        m_dout = '0; m_drv[0] = '0; m_drv[1] = '0; m_pull[0] = '0; m_pull[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the pads and in every word
        chk(pad_oe === '0 && pad_out === '0, "R1 pads quiet", {pad_oe, pad_out}, 64'd0);
        chk(pad_pull === '0 && pad_drive === '0, "R1 pull/drive zero", pad_pull | pad_drive, 64'd0);
        for (int w = 0; w < 10; w++) rd_chk(w, "R1 reset readback");

        // R3: function word layout read back; R4 inputs
        bus(1'b1, 0, 32'h0000_0000, r); bus(1'b1, 1, 32'h0000_0000, r);
        bus(1'b1, 2, 32'h0000_0000, r); bus(1'b1, 3, 32'h0000_0000, r);
        for (int w = 0; w < 4; w++) rd_chk(w, "R3 fsel readback");
        alt_oe = '1; alt_out = '1;
        @(negedge clk);
        pads_chk("R4 all inputs");

        // R8: synchroniser latency: pad change together with read request
        pad_in = 32'hA5C3_0F96;
        bus(1'b0, 4, 32'd0, r);
        chk(r === 32'd0, "R8 sync old value", {32'd0, r}, 64'd0);
        bus(1'b0, 4, 32'd0, r);
        chk(r === 32'hA5C3_0F96, "R8 sync new value", {32'd0, r}, {32'd0, 32'hA5C3_0F96});

        // R8/R5: mixed modes in the data word
        bus(1'b1, 4, 32'h0F0F_00F0, r);
        bus(1'b1, 0, 32'h1111_1111, r);
        rd_chk(4, "R8 mixed mode data read");
        pads_chk("R5 low byte outputs");

        // R7: disabled pins ignore alternate inputs
        bus(1'b1, 1, 32'h7777_7777, r);
        pads_chk("R7 disabled byte");

        // R2: request held into ST_ACK with altered contents is ignored
        req_valid = 1'b1; req_write = 1'b1; req_word = 4'd5; req_wdata = 32'h0000_1234;
        @(negedge clk);
        chk(req_ack === 1'b1, "R2 ack held req", {63'd0, req_ack}, 64'd1);
        req_word = 4'd6; req_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ack === 1'b0, "R2 no second ack", {63'd0, req_ack}, 64'd0);
        @(negedge clk);
        model_write(5, 32'h0000_1234);
        rd_chk(5, "R2 R9 drive word 5");
        rd_chk(6, "R2 ignored write word 6");

        // R10: pull codes, reserved code
        bus(1'b1, 7, 32'hFFFF_FFFF, r);
        bus(1'b1, 8, 32'h9999_9999, r);
        rd_chk(7, "R10 reserved reads back");
        pads_chk("R10 pull mapping");

        // R11: unmapped words
        for (int w = 9; w < 16; w++) bus(1'b1, w, $urandom, r);
        for (int w = 0; w < 16; w++) rd_chk(w, "R11 map intact / unmapped zero");
        pads_chk("R11 pads unchanged");

        // Random traffic: R3 R5 R6 R8 R9 R10 R11
        for (int i = 0; i < 700; i++) begin
            int w;
            bit we;
            logic [31:0] d;
            pad_in = $urandom; alt_out = $urandom; alt_oe = $urandom;
            repeat (2) @(negedge clk);
            w  = $urandom_range(0, 11);
            we = ($urandom_range(0, 2) != 0);
            d  = $urandom;
            if (we) bus(1'b1, w, d, r);
            else begin
                bus(1'b0, w, 32'd0, r);
                chk(r === exp_read(w, pad_in), "R3 R8 R11 random read",
                    {32'd0, r}, {32'd0, exp_read(w, pad_in)});
            end
            pads_chk("R6 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule